// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Refresh

A synchronous controller that sits between a simple host request port and a 64K x 16 asynchronous DRAM. The host offers one word access at a time with a valid/ready handshake. Each request carries an address, write data and two byte enables. The controller turns each accepted request into one full row/column cycle on the memory. It splits the 16-bit address into an 8-bit row half and an 8-bit column half on a shared address bus. It drives a separate column strobe for each byte lane. It owns a bidirectional 16-bit data bus. Completed reads are reported with a one-clock data-valid pulse.

The controller also keeps the memory alive and legal. After reset it waits a fixed power-up time. It then issues a set number of dummy row-strobe pulses before it accepts the first host request. From then on a free-running timer requests a refresh at a fixed period. Each refresh is performed as column-before-row. A waiting refresh wins over a waiting host request, but it never breaks into a cycle that has already started. Every minimum pulse width, setup and precharge time is a clock-count parameter.

Top module: `adram_ctrl`

## Requirements
- R1: After reset `req_ready` stays low and no column strobe falls. This lasts for at least `INIT_WAIT` clocks followed by `INIT_PULSES` row-strobe pulses; only then may `req_ready` rise.
- R2: A refresh is performed once every `REF_PERIOD` clocks. This rate holds with the host idle and with the host keeping `req_valid` high continuously, because a pending refresh is granted before a waiting request.
- R3: A refresh drives both column strobes low at least one clock before the row strobe falls, with `dram_we_n` and `dram_oe_n` high.
- R4: Every low pulse of `dram_ras_n` lasts at least `T_RAS` clocks, including pulses whose access finished earlier.
- R5: `dram_ras_n` stays high at least `T_RP` clocks before each fall. Each column strobe stays high at least `T_CP` clocks between two falls.
- R6: For an access, `dram_addr` holds `req_addr[15:8]` when the row strobe falls. It holds `req_addr[7:0]` when a column strobe falls and stays unchanged while that strobe is low. The row and column halves therefore select distinct locations.
- R7: `req_be[0]` selects `dram_lcas_n` (data bits 7:0) and `req_be[1]` selects `dram_ucas_n` (data bits 15:8). The strobe of an unselected lane stays high for the whole access.
- R8: On a write, `dram_we_n` is low and the write data is driven on `dram_dq` at least one clock before the column strobe falls. The data written is `req_wdata` on the selected lanes.
- R9: On a read, data is captured only once the column strobe has been low at least `T_CAS` clocks and the row strobe at least `T_RAC` clocks. `rd_valid` is then high for exactly one clock with the captured word on `rd_data`.
- R10: `req_ready` is low while the row strobe is low, during precharge and refresh, and in the clock after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address, row in bits 15:8, column in bits 7:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-clock pulse when read data is captured |
| rd_data | output | 16 | Captured read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_dq | inout | 16 | Bidirectional data bus |

## Verification
Two word writes use addresses whose row and column halves are swapped. Reading both back shows whether the halves reach the bus in the right order. A sequence of full-word, low-only and high-only writes to one location, read back as a full word and as a high byte, shows whether each byte enable reaches its own strobe and whether an unselected lane is left untouched. Refreshes are counted over the same window twice, once with the host idle and once with back-to-back reads. This separates a correct refresh priority from one that starves refresh under load. The read timing is set so that the row-access count outlasts the column count, which shows whether capture waits for both.

// File: rtl/adram_ctrl.sv
`timescale 1ns/1ps
module adram_ctrl #(
  parameter int INIT_WAIT   = 20000,
  parameter int INIT_PULSES = 8,
  parameter int REF_PERIOD  = 1562,
  parameter int T_RAS       = 6,
  parameter int T_RP        = 4,
  parameter int T_CP        = 2,
  parameter int T_RCD       = 2,
  parameter int T_CAS       = 2,
  parameter int T_RAC       = 5,
  parameter int T_CSR       = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  req_be,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        dram_ras_n,
  output logic        dram_lcas_n,
  output logic        dram_ucas_n,
  output logic        dram_we_n,
  output logic        dram_oe_n,
  output logic [7:0]  dram_addr,
  inout  wire  [15:0] dram_dq
);
  localparam int T_PRE = (T_RP > T_CP) ? T_RP : T_CP;

  typedef enum logic [3:0] {
    S_PWR, S_IRAS, S_IPRE, S_IDLE, S_ROW, S_RCD, S_COL,
    S_CAS, S_RHOLD, S_PRE, S_RCAS, S_RRAS
  } st_t;

  st_t st, nxt;
  int cnt, ras_cnt, pulses, ref_tmr;
  logic ref_pend, wr_q, dq_oe;
  logic [1:0] be_q;
  logic [7:0] col_q;
  logic [15:0] wdata_q;

  function automatic logic row_low(st_t s);
    return s inside {S_IRAS, S_RCD, S_COL, S_CAS, S_RHOLD, S_RRAS};
  endfunction

  assign req_ready = (st == S_IDLE) && !ref_pend;
  assign dram_dq   = dq_oe ? wdata_q : 16'hzzzz;

  always_comb begin
    nxt = st;
    case (st)
      S_PWR:   if (cnt >= INIT_WAIT - 1) nxt = S_IRAS;
      S_IRAS:  if (ras_cnt >= T_RAS - 1) nxt = S_IPRE;
      S_IPRE:  if (cnt >= T_PRE - 1) nxt = (pulses >= INIT_PULSES - 1) ? S_IDLE : S_IRAS;
      S_IDLE:  if (ref_pend) nxt = S_RCAS; else if (req_valid) nxt = S_ROW;
      S_ROW:   nxt = S_RCD;
      S_RCD:   if (cnt >= T_RCD - 1) nxt = S_COL;
      S_COL:   nxt = S_CAS;
      S_CAS:   if (cnt >= T_CAS - 1 && ras_cnt >= T_RAC - 1) nxt = S_RHOLD;
      S_RHOLD: if (ras_cnt >= T_RAS - 1) nxt = S_PRE;
      S_PRE:   if (cnt >= T_PRE - 1) nxt = S_IDLE;
      S_RCAS:  if (cnt >= T_CSR - 1) nxt = S_RRAS;
      S_RRAS:  if (ras_cnt >= T_RAS - 1) nxt = S_PRE;
      default: nxt = S_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PWR;
      cnt <= 0;
      ras_cnt <= 0;
      pulses <= 0;
      ref_tmr <= 0;
      ref_pend <= 1'b0;
      wr_q <= 1'b0;
      be_q <= 2'b00;
      col_q <= '0;
      wdata_q <= '0;
      dq_oe <= 1'b0;
      dram_addr <= '0;
      dram_ras_n <= 1'b1;
      dram_lcas_n <= 1'b1;
      dram_ucas_n <= 1'b1;
      dram_we_n <= 1'b1;
      dram_oe_n <= 1'b1;
      rd_valid <= 1'b0;
      rd_data <= '0;
    end else begin
      st <= nxt;
      cnt <= (nxt != st) ? 0 : cnt + 1;
      ras_cnt <= row_low(st) ? ras_cnt + 1 : 0;
      if (st == S_IPRE && nxt != st) pulses <= pulses + 1;

      if (st == S_IDLE && nxt == S_RCAS) ref_pend <= 1'b0;
      if (ref_tmr >= REF_PERIOD - 1) begin
        ref_tmr <= 0;
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr + 1;
      end

      if (st == S_IDLE && nxt == S_ROW) begin
        dram_addr <= req_addr[15:8];
        col_q <= req_addr[7:0];
        wdata_q <= req_wdata;
        be_q <= req_be;
        wr_q <= req_write;
      end
      if (st == S_RCD && nxt == S_COL) dram_addr <= col_q;

      dram_ras_n  <= !row_low(nxt);
      dram_lcas_n <= !((nxt == S_CAS && be_q[0]) || nxt == S_RCAS || nxt == S_RRAS);
      dram_ucas_n <= !((nxt == S_CAS && be_q[1]) || nxt == S_RCAS || nxt == S_RRAS);
      dram_we_n   <= !((nxt == S_COL || nxt == S_CAS) && wr_q);
      dq_oe       <=  (nxt == S_COL || nxt == S_CAS) && wr_q;
      dram_oe_n   <= !(nxt == S_CAS && !wr_q);

      rd_valid <= (st == S_CAS) && (nxt == S_RHOLD) && !wr_q;
      if (st == S_CAS && nxt == S_RHOLD && !wr_q) rd_data <= dram_dq;
    end
  end
endmodule

// File: rtl/adram_ctrl_chk.sv
`timescale 1ns/1ps
module adram_ctrl_chk #(
  parameter int INIT_PULSES = 8,
  parameter int T_RAS       = 6,
  parameter int T_RP        = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n,
  input logic we_n,
  input logic oe_n
);
  int lo_run, hi_run, falls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run <= 0;
      hi_run <= T_RP;
      falls <= 0;
    end else begin
      lo_run <= ras_n ? 0 : lo_run + 1;
      hi_run <= ras_n ? hi_run + 1 : 0;
      if (!ras_n && lo_run == 0 && falls < INIT_PULSES) falls <= falls + 1;
    end
  end

  assert_init_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> falls >= INIT_PULSES);

  assert_cbr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !lcas_n && !ucas_n) |-> ($past(!lcas_n) && $past(!ucas_n) && oe_n && we_n));

  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_run >= T_RAS);

  assert_ras_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_run >= T_RP);

  assert_single_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lcas_n != ucas_n) |-> !ras_n);

  assert_we_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(lcas_n) || $fell(ucas_n)) && !we_n) |-> $past(!we_n));

  assert_rdv_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !req_ready);
endmodule

bind adram_ctrl adram_ctrl_chk #(
  .INIT_PULSES(INIT_PULSES), .T_RAS(T_RAS), .T_RP(T_RP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .ras_n(dram_ras_n), .lcas_n(dram_lcas_n), .ucas_n(dram_ucas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n)
);

// File: tb/adram_ctrl_tb_top.sv
`timescale 1ns/1ps
module adram_ctrl_tb_top;
  localparam int INIT_WAIT = 100, INIT_PULSES = 8, REF_PERIOD = 300;
  localparam int T_RAS = 10, T_RP = 4, T_CP = 2, T_RCD = 2, T_CAS = 3, T_RAC = 8, T_CSR = 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [1:0] req_be = 0;
  logic req_ready, rd_valid, ras_n, lcas_n, ucas_n, we_n, oe_n;
  logic [15:0] rd_data;
  logic [7:0] addr;
  wire [15:0] dq;

  adram_ctrl #(.INIT_WAIT(INIT_WAIT), .INIT_PULSES(INIT_PULSES), .REF_PERIOD(REF_PERIOD),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RAC(T_RAC), .T_CSR(T_CSR)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_lcas_n(lcas_n),
    .dram_ucas_n(ucas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
    .dram_dq(dq));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model, sampled at the falling clock edge
  logic [15:0] mem [logic [15:0]];
  logic [15:0] rd_word = 0;
  logic [7:0] m_row = 0, m_col = 0;
  logic p_ras = 1, p_l = 1, p_u = 1, p_we = 1, in_cbr = 0;
  int lo_run = 0, hi_run = 1000, hi_l = 1000, hi_u = 1000, cas_run = 0;
  int ras_falls = 0, refresh_cnt = 0, lcas_falls = 0, ucas_falls = 0;
  int last_cas_run = 0, last_ras_run = 0;
  int cbr_bad = 0, tras_bad = 0, trp_bad = 0, tcp_bad = 0, addr_bad = 0, wr_bad = 0;

  assign dq[7:0]  = (!ras_n && !lcas_n && !oe_n && we_n) ? rd_word[7:0]  : 8'hzz;
  assign dq[15:8] = (!ras_n && !ucas_n && !oe_n && we_n) ? rd_word[15:8] : 8'hzz;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] k, w;
      bit any_fall;
      any_fall = 0;
      if (!ras_n && !in_cbr && !lcas_n && !p_l && addr != m_col) addr_bad++;
      if (!ras_n && !in_cbr && !ucas_n && !p_u && addr != m_col) addr_bad++;
      if (!lcas_n && p_l) begin
        if (hi_l < T_CP) tcp_bad++;
        if (!ras_n) begin lcas_falls++; any_fall = 1; end
      end
      if (!ucas_n && p_u) begin
        if (hi_u < T_CP) tcp_bad++;
        if (!ras_n) begin ucas_falls++; any_fall = 1; end
      end
      if (any_fall) begin
        m_col = addr;
        k = {m_row, m_col};
        if (!we_n) begin
          w = mem.exists(k) ? mem[k] : 16'h0;
          if (p_we || (!lcas_n && $isunknown(dq[7:0])) || (!ucas_n && $isunknown(dq[15:8]))) wr_bad++;
          if (!lcas_n) w[7:0] = dq[7:0];
          if (!ucas_n) w[15:8] = dq[15:8];
          mem[k] = w;
        end
        rd_word = mem.exists(k) ? mem[k] : 16'h0;
      end
      if (!ras_n && !in_cbr && (!lcas_n || !ucas_n)) cas_run++;
      if (!ras_n && !in_cbr && (!p_l || !p_u) && lcas_n && ucas_n) begin
        last_cas_run = cas_run;
        last_ras_run = lo_run;
        cas_run = 0;
      end
      hi_l = lcas_n ? hi_l + 1 : 0;
      hi_u = ucas_n ? hi_u + 1 : 0;
      if (!ras_n) begin
        if (p_ras) begin
          ras_falls++;
          if (hi_run < T_RP) trp_bad++;
          if (!lcas_n && !ucas_n) begin
            refresh_cnt++;
            in_cbr = 1;
            if (p_l || p_u || !oe_n || !we_n) cbr_bad++;
          end else m_row = addr;
          lo_run = 0;
        end
        lo_run++;
      end else begin
        if (!p_ras) begin
          if (lo_run < T_RAS) tras_bad++;
          hi_run = 0;
          in_cbr = 0;
        end
        hi_run++;
      end
      p_ras = ras_n; p_l = lcas_n; p_u = ucas_n; p_we = we_n;
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 ready after accept", req_ready, 0);
  endtask

  task automatic host_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1, a, d, be);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic host_read(input logic [15:0] a, input logic [1:0] be, input logic [15:0] exp, input logic [15:0] mask);
    int t;
    issue(0, a, 16'h0, be);
    t = 0;
    while (!rd_valid && t < 100) begin @(negedge clk); t++; end
    chk(rd_valid, "R9 rd_valid seen", rd_valid, 1);
    chk((rd_data & mask) == exp, "R9 read data", rd_data & mask, exp);
    @(negedge clk);
    chk(!rd_valid, "R9 rd_valid single clock", rd_valid, 0);
    chk(last_cas_run >= T_CAS && last_ras_run >= T_RAC, "R9 capture timing",
        {last_cas_run[15:0], last_ras_run[15:0]}, {T_CAS[15:0], T_RAC[15:0]});
  endtask

  task automatic t_reset_init();
    int n;
    @(negedge clk);
    chk(!req_ready && ras_n && lcas_n && ucas_n && !rd_valid, "R1 reset state",
        {req_ready, ras_n, lcas_n, ucas_n, rd_valid}, 5'b01110);
    rst_n = 1;
    n = 0;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    chk(n >= INIT_WAIT + INIT_PULSES * T_RAS, "R1 init length", n, INIT_WAIT + INIT_PULSES * T_RAS);
    chk(ras_falls == INIT_PULSES, "R1 init pulses", ras_falls, INIT_PULSES);
    chk(lcas_falls == 0 && ucas_falls == 0 && refresh_cnt == 0, "R1 no column strobe in init",
        lcas_falls + ucas_falls + refresh_cnt, 0);
  endtask

  task automatic t_word();
    host_write(16'h1234, 16'hA5C3, 2'b11);
    chk(m_row == 8'h12 && m_col == 8'h34, "R6 row and column halves", {m_row, m_col}, 16'h1234);
    host_write(16'h3412, 16'h0F1E, 2'b11);
    host_read(16'h1234, 2'b11, 16'hA5C3, 16'hFFFF);
    host_read(16'h3412, 2'b11, 16'h0F1E, 16'hFFFF);
    chk(wr_bad == 0, "R8 write setup", wr_bad, 0);
  endtask

  task automatic t_lanes();
    int l0, u0;
    host_write(16'h5566, 16'h1111, 2'b11);
    l0 = lcas_falls; u0 = ucas_falls;
    host_write(16'h5566, 16'hAB22, 2'b01);
    chk(ucas_falls == u0 && lcas_falls == l0 + 1, "R7 low lane only", {ucas_falls[15:0], lcas_falls[15:0]}, {u0[15:0], l0[15:0] + 16'd1});
    l0 = lcas_falls;
    host_write(16'h5566, 16'h33CD, 2'b10);
    chk(lcas_falls == l0, "R7 high lane only", lcas_falls, l0);
    host_read(16'h5566, 2'b11, 16'h3322, 16'hFFFF);
    l0 = lcas_falls;
    host_read(16'h5566, 2'b10, 16'h3300, 16'hFF00);
    chk(lcas_falls == l0, "R7 high lane read", lcas_falls, l0);
  endtask

  task automatic t_refresh_idle();
    int r0;
    r0 = refresh_cnt;
    repeat (3 * REF_PERIOD) @(negedge clk);
    chk(refresh_cnt - r0 >= 2 && refresh_cnt - r0 <= 4, "R2 idle refresh rate", refresh_cnt - r0, 3);
    chk(cbr_bad == 0, "R3 refresh order", cbr_bad, 0);
  endtask

  task automatic t_refresh_busy();
    int r0, c0;
    r0 = refresh_cnt; c0 = cyc;
    while (cyc - c0 < 3 * REF_PERIOD) host_read(16'h1234, 2'b11, 16'hA5C3, 16'hFFFF);
    chk(refresh_cnt - r0 >= 2, "R2 refresh under load", refresh_cnt - r0, 3);
    chk(cbr_bad == 0, "R3 refresh order under load", cbr_bad, 0);
  endtask

  task automatic t_timing();
    chk(tras_bad == 0, "R4 row strobe width", tras_bad, 0);
    chk(trp_bad == 0 && tcp_bad == 0, "R5 precharge", trp_bad + tcp_bad, 0);
    chk(addr_bad == 0, "R6 column address hold", addr_bad, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset_init();
    t_word();
    t_lanes();
    t_refresh_idle();
    t_refresh_busy();
    t_timing();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule